// File: doc/BRIEF.md
# Character-Based Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display from a single dot clock. Time is kept in three nested counters. A pixel index steps through the dots of one character cell. A character counter steps once per cell. A scanline counter steps once per line. Each axis has six programmable event positions: display end, blank start, sync start, sync end, blank end and total. Comparing the counters against these positions gives the display-enable, blanking, sync and border regions.

Between the end of active display and the start of blanking there is a border region. In that region the block drives a programmable overscan color. A two-bit selector tells the downstream pixel path whether to show fetched video, the border color or black. The timing inputs are copied into shadow registers only on the last dot of a frame, so a frame never uses a mix of old and new settings. After reset, the shadow registers hold build-time defaults until the first frame boundary. The default positions give an 800-dot line and a 525-line frame, which is about 60 frames per second with a 25.2 MHz dot clock.

Top module: `crt_timing_gen`

## Requirements
- R1: `dot_o` counts 0 to CHAR_PX-1 and advances on every clock. `char_o` advances by one only on the clock where `dot_o` wraps from CHAR_PX-1 to 0.
- R2: When a character step would reach the horizontal total, `char_o` returns to 0 and `line_o` advances. `line_o` changes at no other time, apart from a frame wrap.
- R3: When a line step would reach the vertical total, `char_o` and `line_o` both return to 0 and a new frame begins.
- R4: `de_o` is 1 exactly when `char_o` is below the horizontal display end and `line_o` is below the vertical display end.
- R5: `blank_o` is 1 when `char_o` lies in the half-open range [blank start, blank end) of the horizontal axis, or when `line_o` lies in the same range of the vertical axis.
- R6: `hsync_o` is active while `char_o` lies in [sync start, sync end), and `vsync_o` is active while `line_o` lies in its own [sync start, sync end). Active means 1 when SYNC_ACT_HIGH=1 and 0 otherwise.
- R7: `color_sel_o` encodes the pixel source: 1 = video (when `de_o` is 1), 0 = black (blanked and not in display), 2 = border (neither). `color_o` equals `overscan_i` when the selector is 2 and is 0 in every other case.
- R8: The twelve timing inputs take effect only from the first dot after the last dot of a frame. From reset until that first boundary, the block uses the build-time reset values. These default to 80/81/84/96/99/100 characters and 480/487/489/498/516/525 lines.
- R9: While `rst_ni` is low, `dot_o`, `char_o` and `line_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_de_end_i | input | H_W | Horizontal display end, in characters |
| h_blank_start_i | input | H_W | Horizontal blank start |
| h_sync_start_i | input | H_W | Horizontal sync start |
| h_sync_end_i | input | H_W | Horizontal sync end |
| h_blank_end_i | input | H_W | Horizontal blank end |
| h_total_i | input | H_W | Characters per line |
| v_de_end_i | input | V_W | Vertical display end, in lines |
| v_blank_start_i | input | V_W | Vertical blank start |
| v_sync_start_i | input | V_W | Vertical sync start |
| v_sync_end_i | input | V_W | Vertical sync end |
| v_blank_end_i | input | V_W | Vertical blank end |
| v_total_i | input | V_W | Lines per frame |
| overscan_i | input | COLOR_W | Border color |
| de_o | output | 1 | Display enable |
| blank_o | output | 1 | Blanking |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| dot_o | output | DOT_W | Pixel index within the character |
| char_o | output | H_W | Character count |
| line_o | output | V_W | Scanline count |
| color_sel_o | output | 2 | Pixel source select |
| color_o | output | COLOR_W | Border color out, 0 outside the border |

## Verification
The bench keeps the default widths, 8-dot cells and active-high sync. It overrides the reset timing with a 10-character, 9-line frame, so a full frame takes 720 clocks and several frame wraps fit in a short run. The timing inputs are set to a different small frame before reset is released, which shows that the first frame still follows the reset values. A mid-frame change to a third setting then shows that nothing moves until the next boundary. Because the frames are so small, every region edge on both axes is passed many times, including a border column that sits after blank end on each line.

// File: rtl/crt_timing_pkg.sv
package crt_timing_pkg;
  localparam int EV_DE_END      = 0;
  localparam int EV_BLANK_START = 1;
  localparam int EV_SYNC_START  = 2;
  localparam int EV_SYNC_END    = 3;
  localparam int EV_BLANK_END   = 4;
  localparam int EV_TOTAL       = 5;
  localparam int NUM_EV         = 6;

  typedef enum logic [1:0] {
    SEL_BLANK  = 2'd0,
    SEL_VIDEO  = 2'd1,
    SEL_BORDER = 2'd2
  } color_sel_e;
endpackage

// File: rtl/crt_param_shadow.sv
module crt_param_shadow
  import crt_timing_pkg::*;
#(
  parameter int W = 8,
  parameter logic [NUM_EV-1:0][W-1:0] RST_VAL = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [NUM_EV-1:0][W-1:0] d_i,
  output logic [NUM_EV-1:0][W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RST_VAL;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/crt_scan_counters.sv
module crt_scan_counters #(
  parameter int CHAR_PX = 8,
  parameter int DOT_W   = 3,
  parameter int H_W     = 8,
  parameter int V_W     = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [H_W-1:0]   h_total_i,
  input  logic [V_W-1:0]   v_total_i,
  output logic [DOT_W-1:0] dot_o,
  output logic [H_W-1:0]   char_o,
  output logic [V_W-1:0]   line_o,
  output logic             frame_last_o
);
  localparam logic [DOT_W-1:0] DOT_MAX = DOT_W'(CHAR_PX - 1);

  logic dot_last, char_last, line_last;

  assign dot_last  = (dot_o == DOT_MAX);
  // >= keeps the wrap safe for a total of 0
  assign char_last = ({1'b0, char_o} + 1'b1) >= {1'b0, h_total_i};
  assign line_last = ({1'b0, line_o} + 1'b1) >= {1'b0, v_total_i};
  assign frame_last_o = dot_last & char_last & line_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_o  <= '0;
      char_o <= '0;
      line_o <= '0;
    end else begin
      dot_o <= dot_last ? '0 : dot_o + 1'b1;
      if (dot_last) begin
        if (char_last) begin
          char_o <= '0;
          line_o <= line_last ? '0 : line_o + 1'b1;
        end else begin
          char_o <= char_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/crt_axis_decode.sv
module crt_axis_decode
  import crt_timing_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]             cnt_i,
  input  logic [NUM_EV-1:0][W-1:0] tim_i,
  output logic                     disp_o,
  output logic                     blank_o,
  output logic                     sync_o
);
  assign disp_o  = cnt_i < tim_i[EV_DE_END];
  assign blank_o = (cnt_i >= tim_i[EV_BLANK_START]) && (cnt_i < tim_i[EV_BLANK_END]);
  assign sync_o  = (cnt_i >= tim_i[EV_SYNC_START]) && (cnt_i < tim_i[EV_SYNC_END]);
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
  import crt_timing_pkg::*;
#(
  parameter int CHAR_PX       = 8,
  parameter int H_W           = 8,
  parameter int V_W           = 10,
  parameter int COLOR_W       = 8,
  parameter bit SYNC_ACT_HIGH = 1'b1,
  parameter int H_DE_RST      = 80,
  parameter int H_BS_RST      = 81,
  parameter int H_SS_RST      = 84,
  parameter int H_SE_RST      = 96,
  parameter int H_BE_RST      = 99,
  parameter int H_TOT_RST     = 100,
  parameter int V_DE_RST      = 480,
  parameter int V_BS_RST      = 487,
  parameter int V_SS_RST      = 489,
  parameter int V_SE_RST      = 498,
  parameter int V_BE_RST      = 516,
  parameter int V_TOT_RST     = 525,
  localparam int DOT_W        = (CHAR_PX > 1) ? $clog2(CHAR_PX) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [H_W-1:0]     h_de_end_i,
  input  logic [H_W-1:0]     h_blank_start_i,
  input  logic [H_W-1:0]     h_sync_start_i,
  input  logic [H_W-1:0]     h_sync_end_i,
  input  logic [H_W-1:0]     h_blank_end_i,
  input  logic [H_W-1:0]     h_total_i,
  input  logic [V_W-1:0]     v_de_end_i,
  input  logic [V_W-1:0]     v_blank_start_i,
  input  logic [V_W-1:0]     v_sync_start_i,
  input  logic [V_W-1:0]     v_sync_end_i,
  input  logic [V_W-1:0]     v_blank_end_i,
  input  logic [V_W-1:0]     v_total_i,
  input  logic [COLOR_W-1:0] overscan_i,
  output logic               de_o,
  output logic               blank_o,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic [DOT_W-1:0]   dot_o,
  output logic [H_W-1:0]     char_o,
  output logic [V_W-1:0]     line_o,
  output logic [1:0]         color_sel_o,
  output logic [COLOR_W-1:0] color_o
);
  localparam logic [NUM_EV-1:0][H_W-1:0] H_RST = {
    H_W'(H_TOT_RST), H_W'(H_BE_RST), H_W'(H_SE_RST),
    H_W'(H_SS_RST), H_W'(H_BS_RST), H_W'(H_DE_RST)};
  localparam logic [NUM_EV-1:0][V_W-1:0] V_RST = {
    V_W'(V_TOT_RST), V_W'(V_BE_RST), V_W'(V_SE_RST),
    V_W'(V_SS_RST), V_W'(V_BS_RST), V_W'(V_DE_RST)};

  logic [NUM_EV-1:0][H_W-1:0] h_in, h_act;
  logic [NUM_EV-1:0][V_W-1:0] v_in, v_act;
  logic frame_last;
  logic h_disp, h_blank, h_sync, v_disp, v_blank, v_sync;
  color_sel_e sel;

  assign h_in = {h_total_i, h_blank_end_i, h_sync_end_i,
                 h_sync_start_i, h_blank_start_i, h_de_end_i};
  assign v_in = {v_total_i, v_blank_end_i, v_sync_end_i,
                 v_sync_start_i, v_blank_start_i, v_de_end_i};

  crt_param_shadow #(.W(H_W), .RST_VAL(H_RST)) u_h_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(frame_last), .d_i(h_in), .q_o(h_act));
  crt_param_shadow #(.W(V_W), .RST_VAL(V_RST)) u_v_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(frame_last), .d_i(v_in), .q_o(v_act));

  crt_scan_counters #(.CHAR_PX(CHAR_PX), .DOT_W(DOT_W), .H_W(H_W), .V_W(V_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .h_total_i(h_act[EV_TOTAL]), .v_total_i(v_act[EV_TOTAL]),
    .dot_o(dot_o), .char_o(char_o), .line_o(line_o), .frame_last_o(frame_last));

  crt_axis_decode #(.W(H_W)) u_h_dec (
    .cnt_i(char_o), .tim_i(h_act), .disp_o(h_disp), .blank_o(h_blank), .sync_o(h_sync));
  crt_axis_decode #(.W(V_W)) u_v_dec (
    .cnt_i(line_o), .tim_i(v_act), .disp_o(v_disp), .blank_o(v_blank), .sync_o(v_sync));

  assign de_o    = h_disp & v_disp;
  assign blank_o = h_blank | v_blank;

  always_comb begin
    if (de_o)         sel = SEL_VIDEO;
    else if (blank_o) sel = SEL_BLANK;
    else              sel = SEL_BORDER;
  end
  assign color_sel_o = sel;
  assign color_o     = (sel == SEL_BORDER) ? overscan_i : '0;

  generate
    if (SYNC_ACT_HIGH) begin : g_sync_hi
      assign hsync_o = h_sync;
      assign vsync_o = v_sync;
    end else begin : g_sync_lo
      assign hsync_o = ~h_sync;
      assign vsync_o = ~v_sync;
    end
  endgenerate
endmodule

// File: rtl/crt_timing_chk.sv
module crt_timing_chk
  import crt_timing_pkg::*;
#(
  parameter int CHAR_PX = 8,
  parameter int DOT_W   = 3,
  parameter int H_W     = 8,
  parameter int V_W     = 10,
  parameter int COLOR_W = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [DOT_W-1:0]           dot_o,
  input logic [H_W-1:0]             char_o,
  input logic [V_W-1:0]             line_o,
  input logic [NUM_EV-1:0][H_W-1:0] h_act,
  input logic [NUM_EV-1:0][V_W-1:0] v_act,
  input logic                       frame_last,
  input logic                       de_o,
  input logic                       blank_o,
  input logic [1:0]                 color_sel_o,
  input logic [COLOR_W-1:0]         color_o,
  input logic [COLOR_W-1:0]         overscan_i
);
  localparam logic [DOT_W-1:0] DOT_MAX = DOT_W'(CHAR_PX - 1);

  logic line_step;
  assign line_step = (dot_o == DOT_MAX) &&
                     (({1'b0, char_o} + 1'b1) >= {1'b0, h_act[EV_TOTAL]});

  AST_DOT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_o != DOT_MAX) |=> (dot_o == $past(dot_o) + 1'b1)); // R1
  AST_DOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_o == DOT_MAX) |=> (dot_o == '0)); // R1
  AST_CHAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_o != DOT_MAX) |=> $stable(char_o)); // R1
  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_step |=> $stable(line_o)); // R2
  AST_FRAME_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_last |=> (char_o == '0 && line_o == '0 && dot_o == '0)); // R3
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_last |=> ($stable(h_act) && $stable(v_act))); // R8
  AST_BLANK_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_o && !de_o) |-> (color_sel_o == SEL_BLANK && color_o == '0)); // R7
  AST_BORDER_COLOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (color_sel_o == SEL_BORDER) |-> (color_o == overscan_i && !de_o && !blank_o)); // R7
  AST_VIDEO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (color_sel_o == SEL_VIDEO && color_o == '0)); // R7
endmodule

bind crt_timing_gen crt_timing_chk #(
  .CHAR_PX(CHAR_PX), .DOT_W(DOT_W), .H_W(H_W), .V_W(V_W), .COLOR_W(COLOR_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .dot_o(dot_o), .char_o(char_o), .line_o(line_o),
  .h_act(h_act), .v_act(v_act), .frame_last(frame_last), .de_o(de_o),
  .blank_o(blank_o), .color_sel_o(color_sel_o), .color_o(color_o),
  .overscan_i(overscan_i)
);

// File: tb/crt_timing_gen_tb_top.sv
module crt_timing_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H_W = 8;
  localparam int V_W = 10;
  localparam int COLOR_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [H_W-1:0] h_in [6];
  logic [V_W-1:0] v_in [6];
  logic [COLOR_W-1:0] osc;
  logic de_o, blank_o, hsync_o, vsync_o;
  logic [2:0] dot_o;
  logic [H_W-1:0] char_o;
  logic [V_W-1:0] line_o;
  logic [1:0] color_sel_o;
  logic [COLOR_W-1:0] color_o;

  typedef struct {int de; int blank; int hs; int vs; int dot; int chr; int line; int sel;} exp_t;
  exp_t q[$];
  int m_dot, m_chr, m_line;
  int ph[6], pv[6];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crt_timing_gen #(
    .H_DE_RST(4), .H_BS_RST(5), .H_SS_RST(6), .H_SE_RST(7), .H_BE_RST(8), .H_TOT_RST(10),
    .V_DE_RST(3), .V_BS_RST(4), .V_SS_RST(5), .V_SE_RST(6), .V_BE_RST(7), .V_TOT_RST(9)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .h_de_end_i(h_in[0]), .h_blank_start_i(h_in[1]), .h_sync_start_i(h_in[2]),
    .h_sync_end_i(h_in[3]), .h_blank_end_i(h_in[4]), .h_total_i(h_in[5]),
    .v_de_end_i(v_in[0]), .v_blank_start_i(v_in[1]), .v_sync_start_i(v_in[2]),
    .v_sync_end_i(v_in[3]), .v_blank_end_i(v_in[4]), .v_total_i(v_in[5]),
    .overscan_i(osc), .de_o(de_o), .blank_o(blank_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .dot_o(dot_o), .char_o(char_o), .line_o(line_o), .color_sel_o(color_sel_o),
    .color_o(color_o));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_dot = 0; m_chr = 0; m_line = 0;
    ph = '{4, 5, 6, 7, 8, 10};
    pv = '{3, 4, 5, 6, 7, 9};
  endtask

  function automatic exp_t model_out();
    exp_t e;
    int hd, hb, hs, vd, vb, vs;
    hd = m_chr < ph[0];
    hb = (m_chr >= ph[1]) && (m_chr < ph[4]);
    hs = (m_chr >= ph[2]) && (m_chr < ph[3]);
    vd = m_line < pv[0];
    vb = (m_line >= pv[1]) && (m_line < pv[4]);
    vs = (m_line >= pv[2]) && (m_line < pv[3]);
    e.de = hd & vd; e.blank = hb | vb; e.hs = hs; e.vs = vs;
    e.dot = m_dot; e.chr = m_chr; e.line = m_line;
    e.sel = e.de ? 1 : (e.blank ? 0 : 2);
    return e;
  endfunction

  task automatic step();
    int ch[6], cv[6];
    for (int i = 0; i < 6; i++) begin ch[i] = h_in[i]; cv[i] = v_in[i]; end
    @(posedge clk);
    if (m_dot == 7) begin
      m_dot = 0;
      if (m_chr + 1 >= ph[5]) begin
        m_chr = 0;
        if (m_line + 1 >= pv[5]) begin
          m_line = 0;
          ph = ch; pv = cv;
        end else m_line++;
      end else m_chr++;
    end else m_dot++;
    #1 q.push_back(model_out());
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_h(int a, int b, int c, int d, int e, int f);
    h_in[0] = H_W'(a); h_in[1] = H_W'(b); h_in[2] = H_W'(c);
    h_in[3] = H_W'(d); h_in[4] = H_W'(e); h_in[5] = H_W'(f);
  endtask

  task automatic set_v(int a, int b, int c, int d, int e, int f);
    v_in[0] = V_W'(a); v_in[1] = V_W'(b); v_in[2] = V_W'(c);
    v_in[3] = V_W'(d); v_in[4] = V_W'(e); v_in[5] = V_W'(f);
  endtask

  task automatic goto_pos(int c, int l);
    do step(); while (!(m_chr == c && m_line == l && m_dot == 0));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    int exp_color;
    if (q.size() > 0) begin
      e = q.pop_front();
      exp_color = (e.sel == 2) ? int'(osc) : 0;
      chk("R1 dot", int'(dot_o), e.dot);
      chk("R2 char", int'(char_o), e.chr);
      chk("R3 line", int'(line_o), e.line);
      chk("R4 de", int'(de_o), e.de);
      chk("R5 blank", int'(blank_o), e.blank);
      chk("R6 hsync", int'(hsync_o), e.hs);
      chk("R6 vsync", int'(vsync_o), e.vs);
      chk("R7 sel", int'(color_sel_o), e.sel);
      chk("R7 color", int'(color_o), exp_color);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // set A on inputs before reset: must not apply until first frame end (R8)
    set_h(3, 4, 5, 6, 7, 8);
    set_v(2, 3, 4, 5, 6, 8);
    osc = 8'h5A;
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    chk("R9 dot", int'(dot_o), 0);
    chk("R9 char", int'(char_o), 0);
    chk("R9 line", int'(line_o), 0);
    chk("R7 reset sel", int'(color_sel_o), 1);
    @(negedge clk);
    rst_ni = 1'b1;
    // first frame uses reset values: char 3 line 0 still in display (R8)
    goto_pos(3, 0);
    chk("R8 reset timing de", int'(de_o), 1);
    run(20);
    osc = 8'hC3;
    goto_pos(0, 0);
    // set A active now: char 3 line 0 outside display (R8)
    goto_pos(3, 0);
    chk("R8 new timing de", int'(de_o), 0);
    goto_pos(4, 3);
    // mid-frame change to set B
    set_h(2, 3, 4, 6, 7, 9);
    set_v(4, 5, 6, 7, 8, 10);
    goto_pos(3, 4);
    chk("R8 mid-frame held blank", int'(blank_o), 1);
    goto_pos(0, 0);
    run(3 * 8 * 9 * 10);
    osc = 8'h11;
    run(200);
    // second reset mid-frame
    @(negedge clk);
    rst_ni = 1'b0;
    q.delete();
    model_reset();
    #2;
    chk("R9 reset again char", int'(char_o), 0);
    chk("R9 reset again line", int'(line_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    goto_pos(3, 0);
    chk("R8 reset restores defaults de", int'(de_o), 1);
    run(2 * 720 + 100);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule